// File: doc/BRIEF.md
# Fractional Tick Rate Divider

This block creates the count-enable strobe for a PWM counter. Its divisor is a fixed-point number with a whole part and a 4-bit fraction. The effective divisor is the whole part plus the fraction divided by 16. The block adds the fraction into an accumulator on every interval. Each carry out of that accumulator makes the next interval one clock longer. As a result, ticks arrive on average once per divisor clocks, and no interval differs from another by more than one clock.

A 2-bit mode input chooses where ticks come from:
- Free division of the system clock.
- The same division, but it advances only while an external pin is high.
- One tick per synchronised rising edge of the pin.
- One tick per synchronised falling edge of the pin.

The pin passes through a two-stage synchroniser before any use. A separate output reports whether the block runs below full speed.

Control is a two-state machine:
- ST_HOLD is held while the channel enable is low. In ST_HOLD all divider state is cleared.
- When the enable rises, the block moves to ST_RUN at the next edge. That first edge is a load cycle and does not advance the divider.
- When the enable falls, the block returns to ST_HOLD.

Top module: `pwm_tick_divider`

## Requirements
- R1: While `chan_en` is low, `tick` is low, and the counter, accumulator and stretch bit are cleared. After reset, `tick` is low.
- R2: Mode 0 (free) with fraction 0 and whole part W gives one tick every W clocks. The first tick comes W clocks after the load cycle.
- R3: With a non-zero fraction F, the interval is W plus the carry of the previous accumulation. The 4-bit accumulator adds F at each tick. Starting from enable, W=2 and F=5 give exactly 64 ticks in 148 advancing clocks.
- R4: A whole part of 0 acts as 256.
- R5: With a divisor of exactly 1.0 in mode 0, `tick` is high on every clock after the load cycle.
- R6: `slow_rate` is low only when the whole part is 1 and the fraction is 0. In every other case it is high.
- R7: In mode 1 (gated), the divider advances only on clocks where the synchronised pin is high. While the synchronised pin is low, no tick occurs and the count is held.
- R8: In mode 2, each synchronised rising edge of `pin_b` gives exactly one single-cycle tick. The divisor is not used.
- R9: In mode 3, each synchronised falling edge of `pin_b` gives exactly one single-cycle tick.
- R10: `pin_b` goes through two flops before edge detection. A pin edge applied between clock edges shows on `tick` after the third following rising clock edge.
- R11: The first clock edge after `chan_en` rises is a load cycle. It produces no tick and does not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable. When low, holds and clears the divider |
| div_whole | input | 8 | Whole part of the divisor. 0 means 256 |
| div_frac | input | 4 | Fraction of the divisor, in sixteenths |
| mode_sel | input | 2 | 0 free, 1 pin-gated, 2 rising edges, 3 falling edges |
| pin_b | input | 1 | Asynchronous external pin |
| tick | output | 1 | Single-cycle count-enable strobe |
| slow_rate | output | 1 | High when the effective divisor is above 1.0 |

## Verification
The bench uses a cycle model built from the requirements and drives random segments through it. Each segment has a random divisor, mode and enable. During each segment `pin_b` toggles at random, so every mode sees both high and low levels as well as both edge types.

Directed cases isolate specific behaviour:
- A divisor of 1.0 separates the load cycle from steady ticking.
- Fraction 5 over 148 clocks separates correct carry placement from an off-by-one accumulator.
- A whole part of 0 tells 256 apart from a zero-length interval.
- A single pin edge measures the synchroniser depth exactly.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

    typedef enum logic [1:0] {
        MD_FREE  = 2'd0,
        MD_GATED = 2'd1,
        MD_RISE  = 2'd2,
        MD_FALL  = 2'd3
    } div_mode_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;

    // R8/R9: a detected edge lasts one cycle only
    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    a_r9_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/frac_accum_core.sv
module frac_accum_core
    import tdiv_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  div_mode_e         mode,
    input  logic [INT_W-1:0]  whole,
    input  logic [FRAC_W-1:0] frac,
    input  logic              level,
    input  logic              rise,
    input  logic              fall,
    output logic              tick_o
);

    localparam int CNT_W = INT_W + 1;
    localparam logic [CNT_W-1:0] FULL_WHOLE = CNT_W'(1) << INT_W;

    run_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic              ext_q;
    logic              tick_q;

    logic [CNT_W-1:0]  whole_eff;
    logic [CNT_W-1:0]  limit;
    logic              at_end;
    logic [FRAC_W:0]   acc_sum;

    always_comb begin
        whole_eff = (whole == '0) ? FULL_WHOLE : CNT_W'(whole);
        limit     = whole_eff + CNT_W'(ext_q);
        at_end    = (cnt_q >= (limit - CNT_W'(1)));
        acc_sum   = {1'b0, acc_q} + {1'b0, frac};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st_q <= ST_HOLD;
        else if (chan_en) st_q <= ST_RUN;
        else              st_q <= ST_HOLD;
    end

    // Divider datapath and tick output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            ext_q  <= 1'b0;
            tick_q <= 1'b0;
        end else if (!chan_en) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            ext_q  <= 1'b0;
            tick_q <= 1'b0;
        end else if (st_q == ST_HOLD) begin
            tick_q <= 1'b0;
        end else begin
            unique case (mode)
                MD_RISE: tick_q <= rise;
                MD_FALL: tick_q <= fall;
                MD_FREE, MD_GATED: begin
                    if (mode == MD_FREE || level) begin
                        if (at_end) begin
                            tick_q         <= 1'b1;
                            cnt_q          <= '0;
                            {ext_q, acc_q} <= acc_sum;
                        end else begin
                            tick_q <= 1'b0;
                            cnt_q  <= cnt_q + CNT_W'(1);
                        end
                    end else begin
                        tick_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign tick_o = tick_q;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !tick_q);
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_WHOLE);
    a_r5_unity_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && chan_en && mode == MD_FREE && whole == INT_W'(1)
         && frac == '0 && !ext_q) |=> tick_q);
    a_r7_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && chan_en && mode == MD_GATED && !level)
        |=> ($stable(cnt_q) && !tick_q));
    a_r8_edge_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && chan_en && mode == MD_RISE && rise) |=> tick_q);
    a_r11_load_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && chan_en) |=> (!tick_q && cnt_q == '0));

endmodule

// File: rtl/pwm_tick_divider.sv
module pwm_tick_divider
    import tdiv_pkg::*;
#(
    parameter int INT_W       = 8,
    parameter int FRAC_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [INT_W-1:0]  div_whole,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic [1:0]        mode_sel,
    input  logic              pin_b,
    output logic              tick,
    output logic              slow_rate
);

    logic pin_level;
    logic pin_rise;
    logic pin_fall;

    pin_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_b),
        .level_o (pin_level),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    frac_accum_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .mode    (div_mode_e'(mode_sel)),
        .whole   (div_whole),
        .frac    (div_frac),
        .level   (pin_level),
        .rise    (pin_rise),
        .fall    (pin_fall),
        .tick_o  (tick)
    );

    assign slow_rate = !((div_whole == INT_W'(1)) && (div_frac == '0));

    // R6: at full speed, free mode ticks on consecutive clocks
    a_r6_full_speed_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_rate && chan_en && mode_sel == 2'd0 && tick) |=> tick);

endmodule

// File: tb/pwm_tick_divider_tb.sv
`timescale 1ns/1ps
module pwm_tick_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0;
    logic [7:0] div_whole = 8'd1;
    logic [3:0] div_frac = 4'd0;
    logic [1:0] mode_sel = 2'd0;
    logic       pin_b = 1'b0;
    logic       tick;
    logic       slow_rate;

    int checks = 0;
    int fails = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_tick_divider u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .div_whole(div_whole),
        .div_frac(div_frac), .mode_sel(mode_sel), .pin_b(pin_b),
        .tick(tick), .slow_rate(slow_rate)
    );

    // Reference model built from the requirements
    bit m_s1, m_s2, m_d, m_run, m_ext, m_tick;
    int m_cnt;
    int m_acc;

    function automatic int whole_val(input logic [7:0] w);
        return (w == 8'd0) ? 256 : int'(w);
    endfunction

    function automatic bit exp_slow(input logic [7:0] w, input logic [3:0] f);
        return !(w == 8'd1 && f == 4'd0);
    endfunction

    function automatic string tag_for();
        if (!chan_en)         return "R1";
        if (mode_sel == 2'd1) return "R7";
        if (mode_sel == 2'd2) return "R8";
        if (mode_sel == 2'd3) return "R9";
        if (div_frac != 0)    return "R3";
        if (div_whole == 0)   return "R4";
        if (div_whole == 1)   return "R5";
        return "R2";
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_d <= 0; m_run <= 0;
            m_ext <= 0; m_tick <= 0; m_cnt <= 0; m_acc <= 0;
        end else begin
            m_s1 <= pin_b; m_s2 <= m_s1; m_d <= m_s2;
            if (!chan_en) begin
                m_run <= 0; m_cnt <= 0; m_acc <= 0; m_ext <= 0; m_tick <= 0;
            end else if (!m_run) begin
                m_run <= 1; m_tick <= 0;
            end else if (mode_sel == 2'd2) begin
                m_tick <= m_s2 & ~m_d;
            end else if (mode_sel == 2'd3) begin
                m_tick <= ~m_s2 & m_d;
            end else if (mode_sel == 2'd0 || m_s2) begin
                if (m_cnt >= whole_val(div_whole) + int'(m_ext) - 1) begin
                    m_tick <= 1; m_cnt <= 0;
                    m_ext <= (m_acc + int'(div_frac)) >= 16;
                    m_acc <= (m_acc + int'(div_frac)) % 16;
                end else begin
                    m_tick <= 0; m_cnt <= m_cnt + 1;
                end
            end else begin
                m_tick <= 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk); #1;
            if (chk_on) begin
                check(tick == m_tick, tag_for(), int'(tick), int'(m_tick));
                check(slow_rate == exp_slow(div_whole, div_frac), "R6",
                      int'(slow_rate), int'(exp_slow(div_whole, div_frac)));
            end
        end
    end

    task automatic cfg(input bit en, input logic [7:0] w, input logic [3:0] f, input logic [1:0] m);
        @(negedge clk);
        chan_en = en; div_whole = w; div_frac = f; mode_sel = m;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (tick) c++;
        end
    endtask

    task automatic sample_tick(output bit t);
        @(negedge clk); #1;
        t = tick;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int c;
        bit t;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(tick == 1'b0, "R1", int'(tick), 0);
        chk_on = 1'b1;

        // R11 then R5: load cycle, then a tick on every clock
        cfg(1, 8'd1, 4'd0, 2'd0);
        sample_tick(t); check(t == 0, "R11", int'(t), 0);
        sample_tick(t); check(t == 1, "R5", int'(t), 1);
        count_ticks(10, c); check(c == 10, "R5", c, 10);

        // R2: whole 5, fraction 0
        cfg(0, 8'd5, 4'd0, 2'd0);
        cfg(1, 8'd5, 4'd0, 2'd0);
        count_ticks(21, c); check(c == 4, "R2", c, 4);

        // R3: whole 2, fraction 5 gives 64 ticks over 148 advancing clocks
        cfg(0, 8'd2, 4'd5, 2'd0);
        cfg(1, 8'd2, 4'd5, 2'd0);
        count_ticks(149, c); check(c == 64, "R3", c, 64);

        // R4: a whole part of 0 acts as 256
        cfg(0, 8'd0, 4'd0, 2'd0);
        cfg(1, 8'd0, 4'd0, 2'd0);
        count_ticks(513, c); check(c == 2, "R4", c, 2);

        // R10 with R8: a rising pin edge appears after the third clock edge
        cfg(1, 8'd3, 4'd0, 2'd2);
        pin_b = 0;
        repeat (5) @(negedge clk);
        pin_b = 1;
        sample_tick(t); check(t == 0, "R10", int'(t), 0);
        sample_tick(t); check(t == 0, "R10", int'(t), 0);
        sample_tick(t); check(t == 1, "R10", int'(t), 1);
        sample_tick(t); check(t == 0, "R8", int'(t), 0);

        // R9: a falling edge in mode 3
        cfg(1, 8'd3, 4'd0, 2'd3);
        repeat (4) @(negedge clk);
        pin_b = 0;
        count_ticks(6, c); check(c == 1, "R9", c, 1);

        // R7: a low pin freezes the gated divider
        cfg(1, 8'd1, 4'd0, 2'd1);
        count_ticks(10, c); check(c == 0, "R7", c, 0);
        pin_b = 1;
        count_ticks(10, c); check(c == 8, "R7", c, 8);

        // R6: the slow-rate flag under directed divisors
        cfg(1, 8'd1, 4'd1, 2'd0); #1; check(slow_rate == 1, "R6", int'(slow_rate), 1);
        cfg(1, 8'd0, 4'd0, 2'd0); #1; check(slow_rate == 1, "R6", int'(slow_rate), 1);
        cfg(1, 8'd1, 4'd0, 2'd0); #1; check(slow_rate == 0, "R6", int'(slow_rate), 0);

        // Random segments checked cycle by cycle against the model
        for (int s = 0; s < 40; s++) begin
            logic [7:0] w;
            int len;
            w = ($urandom_range(0, 19) == 0) ? 8'd0 : 8'($urandom_range(1, 12));
            cfg(($urandom_range(0, 9) != 0), w, 4'($urandom_range(0, 15)),
                2'($urandom_range(0, 3)));
            len = $urandom_range(50, 400);
            for (int k = 0; k < len; k++) begin
                @(negedge clk);
                if ($urandom_range(0, 3) == 0) pin_b = ~pin_b;
            end
        end

        chk_on = 1'b0;
        finish_run();
    end

endmodule